// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked system read and write an external asynchronous static RAM of 256K bytes. On the system side it takes one request at a time through a valid/ready handshake that carries an address, write data and a direction flag. A read returns its byte on a separate response strobe. On the memory side it drives a pair of chip selects of opposite polarity, active-low write and output enables, the address, and a data bus that is split into outgoing data, incoming data and a drive enable for the pad.

Every minimum time of the memory, in nanoseconds, is converted into a whole number of clock cycles by compile-time parameters, with the clock period itself as a parameter. Each access is then sequenced by a cycle counter. The controller never drives the data bus while the memory may still be driving it. After every read it inserts one deselected cycle before it accepts further work.

Top module: `sram_async_ctrl`

## Requirements
- R1: Whenever no access is in progress (after reset and between accesses), the memory is deselected: `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_drive`=0.
- R2: A read (request with `req_write`=0) keeps `mem_cs_n`=0, `mem_cs`=1, `mem_we_n`=1 and `mem_oe_n`=0 for exactly RD = max(ceil(70/T), ceil(35/T)) cycles, where T is the clock period in ns. `mem_dq_in` is sampled on the last of those cycles, at least 70 ns after the address settled and at least 35 ns after `mem_oe_n` fell.
- R3: The sampled byte appears on `rsp_rdata` together with a `rsp_valid` pulse exactly one cycle long. `rsp_rdata` keeps that value until the next read completes.
- R4: A write (request with `req_write`=1) keeps both selects active for WR = max(ceil(70/T), WEL+1) cycles. `mem_we_n` is low for the first WEL = max(ceil(50/T), REL+SD) of them, and `mem_oe_n` stays high for the whole write.
- R5: `mem_dq_drive` rises REL = ceil(25/T) cycles after `mem_we_n` falls and stays high through the first cycle after `mem_we_n` rises. Write data is therefore stable at least SD = ceil(30/T) cycles (at least 30 ns) before the rising edge of `mem_we_n`.
- R6: `mem_dq_drive` is never high while the memory may drive the bus, which is while it is selected with `mem_oe_n` low and `mem_we_n` high, or within 25 ns after that condition ends.
- R7: Each read is followed by one cycle in which the memory is deselected and `req_ready` is low. This is the cycle of the `rsp_valid` pulse.
- R8: Address, write data and direction are captured when a request is accepted (`req_valid` and `req_ready` high at a rising clock edge). Changes on those inputs during the access have no effect on it.
- R9: `req_ready` is low from the cycle after acceptance until the access finishes. A `req_valid` that is raised and dropped during that time starts no access.
- R10: After reset, `req_ready`=1 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (18) | Word address |
| req_wdata | input | DATA_W (8) | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse when read data is available |
| rsp_rdata | output | DATA_W (8) | Byte returned by the last read |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_cs | output | 1 | Memory select, active high |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W (18) | Memory address |
| mem_dq_out | output | DATA_W (8) | Data toward the memory |
| mem_dq_in | input | DATA_W (8) | Data from the memory |
| mem_dq_drive | output | 1 | Enables the controller's data pad drivers |

## Verification
The bench puts a timing-aware memory model behind the controller. The model flags a drive enable that overlaps the memory's own output or its 25 ns release window. A design with a missing read gap, or with a drive enable that rises too early, would show up there as contention. The model also measures the write enable pulse and the data setup before the write enable rises, so a shortened pulse or late data reports a short interval. The read capture instant is compared against the address change and the output-enable fall, which catches a design that samples one cycle early. Requests that are scrambled or pulsed mid-access are followed by read-backs: a controller that forgets to register its inputs either writes to the wrong address or runs a second access.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
// Shared types and compile-time helpers for the SRAM access sequencer.
package sram_ctl_pkg;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_GAP   = 2'd3
    } st_e;

    // Memory control pins as one registered bundle.
    typedef struct packed {
        logic sel;   // both chip selects active
        logic we_n;  // write enable, active low
        logic oe_n;  // output enable, active low
        logic drv;   // controller data drivers on
    } pin_s;

    localparam pin_s PINS_IDLE = '{sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

    // Integer ceiling division used to turn nanoseconds into cycles.
    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_step_counter.sv
`timescale 1ns/1ps
// Cycle counter for the access phases.
// Restarts from zero in the cycle after restart_i and otherwise counts up.
// It may wrap while idle, because every access restarts it.
// Exposes both the current and the next value so that the pin decode can
// be registered without adding a cycle of delay.
module sram_step_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o
);

    // Next count value.
    always_comb begin
        cnt_d_o = restart_i ? '0 : cnt_q_o + CNT_W'(1);
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q_o <= '0;
        else        cnt_q_o <= cnt_d_o;
    end

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
// Access sequencer: accepts one request at a time and walks a read or a
// write through its cycle-counted phases.
// The memory control pins are decoded from the next state and the next
// count, and then registered, so the pins never glitch.
// Assumes WEL_CYC >= REL_CYC + 1 and WR_CYC >= WEL_CYC + 1, which the
// parameter derivation in the top level guarantees.
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int RD_CYC  = 7,
    parameter int WR_CYC  = 7,
    parameter int WEL_CYC = 6,
    parameter int REL_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic [CNT_W-1:0] cnt_q_i,
    input  logic [CNT_W-1:0] cnt_d_i,
    output logic             restart_o,
    output logic             accept_o,
    output logic             ready_o,
    output logic             rd_done_o,
    output pin_s             pins_o
);

    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] WEL_END = CNT_W'(WEL_CYC);
    localparam logic [CNT_W-1:0] REL_BEG = CNT_W'(REL_CYC);

    st_e  state_q, state_d;
    pin_s pins_q, pins_d;

    assign ready_o  = (state_q == ST_IDLE);
    assign accept_o = ready_o & req_valid_i;
    assign pins_o   = pins_q;

    // Next-state logic and phase-end strobes.
    always_comb begin
        state_d   = state_q;
        restart_o = 1'b0;
        rd_done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_o) begin
                    state_d   = req_write_i ? ST_WRITE : ST_READ;
                    restart_o = 1'b1;
                end
            end
            ST_READ: begin
                if (cnt_q_i == RD_LAST) begin
                    state_d   = ST_GAP;
                    rd_done_o = 1'b1;
                end
            end
            ST_WRITE: begin
                if (cnt_q_i == WR_LAST) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Pin values for the coming cycle.
    always_comb begin
        pins_d = PINS_IDLE;
        unique case (state_d)
            ST_READ: begin
                pins_d.sel  = 1'b1;
                pins_d.oe_n = 1'b0;
            end
            ST_WRITE: begin
                pins_d.sel  = 1'b1;
                pins_d.we_n = !(cnt_d_i < WEL_END);
                pins_d.drv  = (cnt_d_i >= REL_BEG) && (cnt_d_i <= WEL_END);
            end
            default: pins_d = PINS_IDLE;
        endcase
    end

    // State and pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pins_q  <= PINS_IDLE;
        end else begin
            state_q <= state_d;
            pins_q  <= pins_d;
        end
    end

    // R1: idle and gap cycles keep the memory deselected.
    p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_GAP) |-> (!pins_q.sel && pins_q.we_n && pins_q.oe_n && !pins_q.drv));

    // R2: output enable is only ever low during a selected read.
    p_oe_read_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_q.oe_n |-> (pins_q.sel && pins_q.we_n && !pins_q.drv));

    // R4: the write enable pulse happens selected and with outputs disabled.
    p_we_no_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_q.we_n |-> (pins_q.sel && pins_q.oe_n));

    // R5: drivers turn on only after the write enable has been low.
    p_drive_after_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pins_q.drv |-> (pins_q.oe_n && $past(!pins_q.we_n)));

    // R7: the cycle after read capture is deselected and not ready.
    p_gap_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_o |=> (!ready_o && !pins_q.sel && !pins_q.drv));

    // R9: the handshake never offers ready while the memory is selected.
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pins_q.sel |-> !ready_o);

endmodule

// File: rtl/sram_data_path.sv
`timescale 1ns/1ps
// Request and response registers.
// Holds address and write data from acceptance until the next acceptance,
// and captures the memory byte on the final read cycle with a one-cycle
// valid strobe. Assumes accept_i is only high while ready_i is high.
module sram_data_path #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              ready_i,
    input  logic              rd_done_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] mem_dq_in_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o  <= '0;
            wdata_o <= '0;
        end else if (accept_i) begin
            addr_o  <= req_addr_i;
            wdata_o <= req_wdata_i;
        end
    end

    // Read data capture and response strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_done_i;
            if (rd_done_i) rdata_o <= mem_dq_in_i;
        end
    end

    // R3: the response strobe lasts a single cycle.
    p_rvalid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |=> !rvalid_o);

    // R8: address and data stay put while an access runs.
    p_hold_during_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> ($stable(addr_o) && $stable(wdata_o)));

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
// Synchronous controller for an external asynchronous 256K x 8 SRAM.
// Converts the memory's nanosecond minimums into cycle counts at elaboration
// time (clock period CLK_NS) and sequences one access per request.
// Assumes the pad logic turns mem_dq_drive into a tristate enable and
// feeds the pad's input back on mem_dq_in.
module sram_async_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS          = 10,
    parameter int ADDR_W          = 18,
    parameter int DATA_W          = 8,
    parameter int T_CYCLE_NS      = 70,
    parameter int T_OE_ACCESS_NS  = 35,
    parameter int T_WE_PULSE_NS   = 50,
    parameter int T_DATA_SETUP_NS = 30,
    parameter int T_RELEASE_NS    = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_drive
);

    localparam int RD_CYC  = imax(cdiv(T_CYCLE_NS, CLK_NS), cdiv(T_OE_ACCESS_NS, CLK_NS));
    localparam int REL_CYC = imax(1, cdiv(T_RELEASE_NS, CLK_NS));
    localparam int SD_CYC  = imax(1, cdiv(T_DATA_SETUP_NS, CLK_NS));
    localparam int WEL_CYC = imax(cdiv(T_WE_PULSE_NS, CLK_NS), REL_CYC + SD_CYC);
    localparam int WR_CYC  = imax(cdiv(T_CYCLE_NS, CLK_NS), WEL_CYC + 1);
    localparam int CNT_W   = $clog2(imax(RD_CYC, WR_CYC) + 1);

    logic             restart, accept, rd_done;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    pin_s             pins;

    sram_step_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .cnt_q_o   (cnt_q),
        .cnt_d_o   (cnt_d)
    );

    sram_seq_fsm #(
        .CNT_W   (CNT_W),
        .RD_CYC  (RD_CYC),
        .WR_CYC  (WR_CYC),
        .WEL_CYC (WEL_CYC),
        .REL_CYC (REL_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .cnt_q_i     (cnt_q),
        .cnt_d_i     (cnt_d),
        .restart_o   (restart),
        .accept_o    (accept),
        .ready_o     (req_ready),
        .rd_done_o   (rd_done),
        .pins_o      (pins)
    );

    sram_data_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .ready_i     (req_ready),
        .rd_done_i   (rd_done),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .mem_dq_in_i (mem_dq_in),
        .addr_o      (mem_addr),
        .wdata_o     (mem_dq_out),
        .rdata_o     (rsp_rdata),
        .rvalid_o    (rsp_valid)
    );

    assign mem_cs_n     = ~pins.sel;
    assign mem_cs       = pins.sel;
    assign mem_we_n     = pins.we_n;
    assign mem_oe_n     = pins.oe_n;
    assign mem_dq_drive = pins.drv;

    // R6: the controller never drives while the memory output is enabled.
    p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_drive |-> (mem_oe_n || mem_cs_n || !mem_cs));

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench for the SRAM controller: a timing-aware memory model, a table of
// accesses walked by one loop, then directed corner cases.
module sram_async_ctrl_tb_top;

    localparam int CLK_NS = 5;

    function automatic int cd(input int n, input int d); return (n + d - 1) / d; endfunction
    function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction

    // Expected cycle counts, derived from the requirement formulas.
    localparam int E_RD  = mx(cd(70, CLK_NS), cd(35, CLK_NS));
    localparam int E_REL = mx(1, cd(25, CLK_NS));
    localparam int E_SD  = mx(1, cd(30, CLK_NS));
    localparam int E_WEL = mx(cd(50, CLK_NS), E_REL + E_SD);
    localparam int E_WR  = mx(cd(70, CLK_NS), E_WEL + 1);
    localparam int E_DRV = E_WEL - E_REL + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_drive;
    logic [17:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sram_async_ctrl #(.CLK_NS(CLK_NS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_drive(mem_dq_drive)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $realtime);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem    [logic [17:0]];
    logic [7:0] shadow [logic [17:0]];
    logic model_en;
    realtime t_addr = -1000.0, t_oe = -1000.0, t_rel = -1000.0, t_we = -1000.0, t_dchg = -1000.0;

    assign model_en = !mem_cs_n && mem_cs && mem_we_n && !mem_oe_n;

    function automatic logic [7:0] mem_get(input logic [17:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(mem_addr) t_addr = $realtime;
    always @(negedge mem_oe_n) t_oe = $realtime;
    always @(negedge model_en) t_rel = $realtime;
    always @(negedge mem_we_n) t_we = $realtime;
    always @(mem_dq_out or mem_dq_drive) t_dchg = $realtime;

    // Write lands on the rising write enable; pulse width and setup are measured.
    always @(posedge mem_we_n) begin
        if (rst_n && !mem_cs_n && mem_cs) begin
            chk(($realtime - t_we) >= 49.99, "R4 we pulse ns", int'($realtime - t_we), 50);
            chk(mem_dq_drive && (($realtime - t_dchg) >= 29.99), "R5 data setup ns",
                int'($realtime - t_dchg), 30);
            mem[mem_addr] = mem_dq_out;
        end
    end

    // Memory output, refreshed between clock edges.
    initial begin
        #0.25;
        forever begin
            #0.5;
            mem_dq_in = model_en ? mem_get(mem_addr) : 8'h00;
        end
    end

    // ---------------- monitor ----------------
    int n_sel, n_we, n_oe, n_drv, n_rv, n_cont;
    logic [7:0] rv_data;
    bit rv_ready, rv_sel, rd_tim_ok;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n && mem_cs) n_sel++;
            if (!mem_we_n) n_we++;
            if (!mem_oe_n) n_oe++;
            if (mem_dq_drive) n_drv++;
            if (mem_dq_drive && (model_en || ($realtime - t_rel) < 25.0)) begin
                n_cont++;
                chk(1'b0, "R6 bus contention", 1, 0);
            end
            if (rsp_valid) begin
                n_rv++;
                rv_data  = rsp_rdata;
                rv_ready = req_ready;
                rv_sel   = !mem_cs_n || mem_cs;
                rd_tim_ok = (($realtime - 2.5 - t_addr) >= 69.99) && (($realtime - 2.5 - t_oe) >= 34.99);
            end
        end
    end

    // One access; scr scrambles inputs after acceptance, junk pulses req_valid mid-access.
    task automatic access(input logic w, input logic [17:0] a, input logic [7:0] d,
                          input bit scr, input bit junk);
        @(negedge clk); #1;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        #1;
        n_sel = 0; n_we = 0; n_oe = 0; n_drv = 0; n_rv = 0;
        @(negedge clk); #1;
        req_valid = 1'b0;
        if (scr) begin
            req_write = ~w; req_addr = a ^ 18'h00001; req_wdata = ~d;
        end
        if (junk) begin
            req_valid = 1'b1;
            repeat (3) @(negedge clk);
            #1 req_valid = 1'b0;
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (w) shadow[a] = d;
    endtask

    task automatic check_access(input logic w, input logic [17:0] a, input string tag);
        if (w) begin
            chk(n_sel == E_WR,  {"R4 write length ", tag}, n_sel, E_WR);
            chk(n_we  == E_WEL, {"R4 we low cycles ", tag}, n_we, E_WEL);
            chk(n_oe  == 0,     {"R4 oe during write ", tag}, n_oe, 0);
            chk(n_drv == E_DRV, {"R5 drive cycles ", tag}, n_drv, E_DRV);
        end else begin
            logic [7:0] exp;
            exp = shadow.exists(a) ? shadow[a] : 8'h00;
            chk(n_sel == E_RD, {"R2 read length ", tag}, n_sel, E_RD);
            chk(n_oe  == E_RD, {"R2 oe low cycles ", tag}, n_oe, E_RD);
            chk(rd_tim_ok,     {"R2 sample time ", tag}, 0, 1);
            chk(n_rv == 1,     {"R3 rsp_valid pulses ", tag}, n_rv, 1);
            chk(rv_data == exp, {"R2 read data ", tag}, rv_data, exp);
            chk(!rv_ready && !rv_sel, {"R7 gap after read ", tag}, {rv_ready, rv_sel}, 0);
        end
    endtask

    // {write, address, data}
    localparam logic [26:0] VEC [10] = '{
        {1'b1, 18'h00000, 8'h3C},
        {1'b1, 18'h3FFFF, 8'hC3},
        {1'b1, 18'h12345, 8'hA5},
        {1'b0, 18'h00000, 8'h00},
        {1'b0, 18'h3FFFF, 8'h00},
        {1'b1, 18'h00100, 8'hFF},
        {1'b0, 18'h12345, 8'h00},
        {1'b0, 18'h00100, 8'h00},
        {1'b1, 18'h2AAAA, 8'h00},
        {1'b0, 18'h2AAAA, 8'h00}
    };

    initial begin : watchdog
        #(200000 * CLK_NS);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 and R1: state after reset.
        chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R10 reset handshake", {req_ready, rsp_valid}, 2);
        chk(mem_cs_n === 1'b1 && mem_cs === 1'b0 && mem_we_n === 1'b1 && mem_oe_n === 1'b1
            && mem_dq_drive === 1'b0, "R1 reset deselect",
            {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_drive}, 5'b10110);

        // Table walk.
        for (int i = 0; i < 10; i++) begin
            access(VEC[i][26], VEC[i][25:8], VEC[i][7:0], 1'b0, 1'b0);
            check_access(VEC[i][26], VEC[i][25:8], $sformatf("vec%0d", i));
        end

        // R1: deselected between accesses.
        chk(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_drive, "R1 idle deselect",
            {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_drive}, 5'b10110);

        // R8 and R9: write with scrambled inputs and a stray request mid-access.
        access(1'b1, 18'h0ABCE, 8'h99, 1'b0, 1'b0);
        access(1'b1, 18'h0ABCD, 8'h77, 1'b1, 1'b1);
        chk(n_sel == E_WR, "R9 single access despite stray request", n_sel, E_WR);
        access(1'b0, 18'h0ABCD, 8'h00, 1'b0, 1'b0);
        chk(rv_data == 8'h77, "R8 write target", rv_data, 8'h77);
        access(1'b0, 18'h0ABCC, 8'h00, 1'b0, 1'b0);
        chk(rv_data == 8'h00, "R8 neighbour below untouched", rv_data, 8'h00);
        access(1'b0, 18'h0ABCE, 8'h00, 1'b0, 1'b0);
        chk(rv_data == 8'h99, "R8 neighbour above untouched", rv_data, 8'h99);

        // R8: read with scrambled inputs still reads the accepted address.
        access(1'b0, 18'h12345, 8'h00, 1'b1, 1'b0);
        check_access(1'b0, 18'h12345, "scrambled read");

        // R3: read data is held through a following write.
        access(1'b1, 18'h00200, 8'h5A, 1'b0, 1'b0);
        chk(rsp_rdata == 8'hA5 && !rsp_valid, "R3 rdata held", rsp_rdata, 8'hA5);

        // R6: no contention seen anywhere in the run.
        chk(n_cont == 0, "R6 contention total", n_cont, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule